// File: doc/BRIEF.md
# Configurable asynchronous serial transmitter

This block turns characters into asynchronous frames on one transmit line. A frame is a low start bit, then 5 to 9 data bits in either order, an optional parity bit and 1, 1.5 or 2 stop bits. An optional run of idle bit periods may follow before the next start bit. All timing is counted on an external baud strobe that pulses sixteen times per bit period. The half-bit needed for 1.5 stop bits comes from the same oversample count.

One holding register sits in front of the shifter, so software can write the next character while the current one is still going out. A break command holds the line low once the current frame has finished. A second command ends the break. The frame-format inputs are sampled live, so they must stay stable while the empty flag is low.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the line is high, the ready flag is 1 and the empty flag is 1. The line is high whenever the transmitter is empty.
- R2: Each frame starts with a low start bit. Every bit period lasts OVERSAMPLE baud strobes. Clock cycles without a strobe do not advance the frame. With the 9-bit flag clear, length code 0, 1, 2 or 3 sends 5, 6, 7 or 8 data bits.
- R3: With the 9-bit flag set, the length code is ignored and bits 8:0 of the written word are sent as 9 data bits.
- R4: Parity code 0 sends a bit that makes the number of ones in data plus parity even. Code 1 makes that number odd. Code 2 sends a 0 and code 3 sends a 1. Codes 4 and above send no parity bit.
- R5: Stop code 0 gives a high stop time of 1 bit period, code 1 gives 1.5 bit periods and code 2 gives 2 bit periods. Code 3 behaves like code 0.
- R6: With the order flag clear, data bit 0 is sent first. With it set, the highest data bit of the selected length is sent first.
- R7: A guard value G keeps the line high for G more bit periods after the stop time, before the next start bit. G = 0 adds no gap.
- R8: The invert flag inverts the data bits and the parity bit on the line. It does not invert the start, stop, guard or idle levels. Parity is computed on the data before inversion.
- R9: A break-start pulse lets any frame in progress finish and then holds the line low. The line stays low until a break-stop pulse. The cycle after that pulse the line is idle high. A character that is waiting is then sent.
- R10: Writing a character clears the ready flag on the next cycle. Ready sets again in the cycle the shifter takes the character, which is also the cycle its start bit appears. The empty flag is 1 only when the holding register is empty and no frame, gap or break is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Oversample strobe, OVERSAMPLE pulses per bit |
| wr_data | input | 9 | Character to send |
| wr_en | input | 1 | Write strobe for wr_data |
| len_sel | input | 2 | Data length code (5 to 8 bits) |
| nine_bit | input | 1 | Send 9 data bits |
| par_sel | input | 3 | Parity code |
| stop_sel | input | 2 | Stop time code |
| msb_first | input | 1 | Send the most significant data bit first |
| guard_len | input | GUARD_W | Idle bit periods between frames |
| invert | input | 1 | Invert data and parity on the line |
| brk_start | input | 1 | Start a break after the current frame |
| brk_stop | input | 1 | End the break |
| tx_line | output | 1 | Serial output |
| hold_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | No character held or in flight |

## Verification
The bench builds the block with the default OVERSAMPLE of 16 and GUARD_W of 8, and drives the baud strobe on every other clock. A bit period is therefore 32 clocks. That makes the half-bit stop time and the skipped non-strobe cycles visible as exact cycle counts between start edges. Guard values are kept small (0 to 5), so frames of every length, parity, stop and order combination fit many times into one run. The break is placed in the middle of a frame, with a character waiting behind it.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int OVERSAMPLE = 16,
  parameter int GUARD_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic [8:0]         wr_data,
  input  logic               wr_en,
  input  logic [1:0]         len_sel,
  input  logic               nine_bit,
  input  logic [2:0]         par_sel,
  input  logic [1:0]         stop_sel,
  input  logic               msb_first,
  input  logic [GUARD_W-1:0] guard_len,
  input  logic               invert,
  input  logic               brk_start,
  input  logic               brk_stop,
  output logic               tx_line,
  output logic               hold_ready,
  output logic               tx_empty
);

  localparam int TW = $clog2(2*OVERSAMPLE) + 1;
  localparam logic [TW-1:0] LAST_ONE  = TW'(OVERSAMPLE - 1);
  localparam logic [TW-1:0] LAST_HALF = TW'(OVERSAMPLE + OVERSAMPLE/2 - 1);
  localparam logic [TW-1:0] LAST_TWO  = TW'(2*OVERSAMPLE - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_GUARD, S_BRK} tx_state_t;

  tx_state_t          st;
  logic [8:0]         hold_q, shf_q;
  logic               hold_v, brk_pend;
  logic [TW-1:0]      os_cnt;
  logic [GUARD_W-1:0] bit_cnt;

  logic [3:0]    nbits, idx;
  logic [8:0]    dmask;
  logic          has_par, par_calc, par_bit, cur_data;
  logic [TW-1:0] stop_last;
  logic          bit_end, stop_end, free, load;

  assign nbits    = nine_bit ? 4'd9 : 4'd5 + {2'b00, len_sel};
  assign dmask    = 9'h1FF >> (4'd9 - nbits);
  assign has_par  = (par_sel < 3'd4);
  assign par_calc = ^(shf_q & dmask);
  assign idx      = msb_first ? (nbits - 4'd1 - bit_cnt[3:0]) : bit_cnt[3:0];
  assign cur_data = shf_q[idx];

  always_comb begin
    case (par_sel[1:0])
      2'd0:    par_bit = par_calc;
      2'd1:    par_bit = ~par_calc;
      2'd2:    par_bit = 1'b0;
      default: par_bit = 1'b1;
    endcase
    case (stop_sel)
      2'd1:    stop_last = LAST_HALF;
      2'd2:    stop_last = LAST_TWO;
      default: stop_last = LAST_ONE;
    endcase
  end

  assign bit_end  = baud_tick && (os_cnt == LAST_ONE);
  assign stop_end = baud_tick && (os_cnt == stop_last);
  assign free = (st == S_IDLE)
             || (st == S_STOP  && stop_end && guard_len == '0)
             || (st == S_GUARD && bit_end  && (bit_cnt + 1'b1) == guard_len);
  assign load = free && !brk_pend && hold_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_v   <= 1'b0;
      brk_pend <= 1'b0;
    end else begin
      if (wr_en) begin
        hold_q <= wr_data;
        hold_v <= 1'b1;
      end else if (load) begin
        hold_v <= 1'b0;
      end
      if (brk_stop)       brk_pend <= 1'b0;
      else if (brk_start) brk_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      shf_q   <= '0;
      os_cnt  <= '0;
      bit_cnt <= '0;
    end else if (free) begin
      os_cnt  <= '0;
      bit_cnt <= '0;
      if (brk_pend)    st <= S_BRK;
      else if (hold_v) begin
        st    <= S_START;
        shf_q <= hold_q;
      end else         st <= S_IDLE;
    end else begin
      case (st)
        S_START: if (baud_tick) begin
          if (bit_end) begin
            os_cnt  <= '0;
            bit_cnt <= '0;
            st      <= S_DATA;
          end else os_cnt <= os_cnt + 1'b1;
        end
        S_DATA: if (baud_tick) begin
          if (bit_end) begin
            os_cnt <= '0;
            if (bit_cnt[3:0] == nbits - 4'd1) begin
              bit_cnt <= '0;
              st      <= has_par ? S_PAR : S_STOP;
            end else bit_cnt <= bit_cnt + 1'b1;
          end else os_cnt <= os_cnt + 1'b1;
        end
        S_PAR: if (baud_tick) begin
          if (bit_end) begin
            os_cnt <= '0;
            st     <= S_STOP;
          end else os_cnt <= os_cnt + 1'b1;
        end
        S_STOP: if (baud_tick) begin
          if (stop_end) begin
            os_cnt  <= '0;
            bit_cnt <= '0;
            st      <= S_GUARD;
          end else os_cnt <= os_cnt + 1'b1;
        end
        S_GUARD: if (baud_tick) begin
          if (bit_end) begin
            os_cnt  <= '0;
            bit_cnt <= bit_cnt + 1'b1;
          end else os_cnt <= os_cnt + 1'b1;
        end
        S_BRK: if (brk_stop) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_START: tx_line = 1'b0;
      S_DATA:  tx_line = cur_data ^ invert;
      S_PAR:   tx_line = par_bit ^ invert;
      S_BRK:   tx_line = 1'b0;
      default: tx_line = 1'b1;
    endcase
  end

  assign hold_ready = !hold_v;
  assign tx_empty   = (st == S_IDLE) && !hold_v;

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (tx_line && hold_ready));

  // R10
  write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_ready);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ready) |-> !tx_line);

  // R2
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && !baud_tick) |=> $stable(tx_line));

  // R9
  break_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BRK && !brk_stop) |=> !tx_line);

endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_en = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic       nine_bit = 1'b0;
  logic [2:0] par_sel = 3'd4;
  logic [1:0] stop_sel = 2'd0;
  logic       msb_first = 1'b0;
  logic [7:0] guard_len = '0;
  logic       invert = 1'b0;
  logic       brk_start = 1'b0;
  logic       brk_stop = 1'b0;
  logic       tx_line, hold_ready, tx_empty;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  serial_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_data(wr_data), .wr_en(wr_en),
    .len_sel(len_sel), .nine_bit(nine_bit), .par_sel(par_sel), .stop_sel(stop_sel),
    .msb_first(msb_first), .guard_len(guard_len), .invert(invert),
    .brk_start(brk_start), .brk_stop(brk_stop),
    .tx_line(tx_line), .hold_ready(hold_ready), .tx_empty(tx_empty));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n) baud_tick <= ~baud_tick;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nb_data();
    return nine_bit ? 9 : 5 + int'(len_sel);
  endfunction

  function automatic int nb_frame();
    return 1 + nb_data() + ((par_sel < 4) ? 1 : 0);
  endfunction

  function automatic int frame_ticks();
    int st;
    st = (stop_sel == 1) ? 24 : (stop_sel == 2) ? 32 : 16;
    return 16 * nb_frame() + st + 16 * int'(guard_len);
  endfunction

  function automatic bit exp_bit(input int j, input logic [8:0] d);
    int n, k;
    bit p;
    n = nb_data();
    if (j == 0) return 1'b0;
    if (j <= n) begin
      k = msb_first ? (n - j) : (j - 1);
      return d[k] ^ invert;
    end
    p = 1'b0;
    for (int i = 0; i < n; i++) p = p ^ d[i];
    case (par_sel)
      3'd0: return p ^ invert;
      3'd1: return ~p ^ invert;
      3'd2: return 1'b0 ^ invert;
      default: return 1'b1 ^ invert;
    endcase
  endfunction

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic write_char(input logic [8:0] d);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fall(output int t);
    while (tx_line !== 1'b0) @(negedge clk);
    t = cyc;
  endtask

  task automatic frame_chk(input int t0, input logic [8:0] d);
    int nf;
    string tag;
    nf = nb_frame();
    for (int j = 0; j < nf; j++) begin
      wait_until(t0 + 16 + 32 * j);
      if (j == 0) tag = "R2 start";
      else if (j <= nb_data()) tag = nine_bit ? "R3 R6 R8 data" : "R2 R6 R8 data";
      else tag = "R4 R8 parity";
      chk(tag, tx_line, exp_bit(j, d));
    end
    wait_until(t0 + 16 + 32 * nf);
    chk("R5 stop level", tx_line, 1);
  endtask

  task automatic gap_chk(input string req, input int dt);
    int e;
    e = 2 * frame_ticks();
    n_chk++;
    if (dt < e - 2 || dt > e + 1) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, dt, e);
    end
  endtask

  task automatic run_pair(input logic [8:0] c1, input logic [8:0] c2);
    int t0, t1, t2;
    write_char(c1);
    chk("R10 ready after write", hold_ready, 0);
    wait_fall(t0);
    chk("R10 ready on load", hold_ready, 1);
    chk("R10 not empty", tx_empty, 0);
    write_char(c2);
    chk("R10 ready cleared", hold_ready, 0);
    frame_chk(t0, c1);
    wait_fall(t1);
    gap_chk("R5 R7 start-to-start", t1 - t0);
    frame_chk(t1, c2);
    while (tx_empty !== 1'b1) @(negedge clk);
    t2 = cyc;
    gap_chk("R5 R7 R10 frame to empty", t2 - t1);
    chk("R1 idle high", tx_line, 1);
  endtask

  task automatic set_cfg(input int l, input bit n9, input int p, input int s,
                         input bit m, input int g, input bit inv);
    len_sel = 2'(l); nine_bit = n9; par_sel = 3'(p); stop_sel = 2'(s);
    msb_first = m; guard_len = 8'(g); invert = inv;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    int t0, s;
    s = $urandom(32'h1234_5678);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset line", tx_line, 1);
    chk("R1 reset ready", hold_ready, 1);
    chk("R1 reset empty", tx_empty, 1);

    set_cfg(3, 0, 4, 0, 0, 0, 0); run_pair(9'h0A5, 9'h03C);
    set_cfg(0, 1, 1, 2, 1, 3, 0); run_pair(9'h1C3, 9'h001);
    set_cfg(0, 0, 0, 1, 0, 5, 1); run_pair(9'h1F5, 9'h00A);
    set_cfg(1, 0, 3, 3, 1, 0, 1); run_pair(9'h02D, 9'h1FF);
    set_cfg(2, 0, 2, 1, 0, 1, 0); run_pair(9'h07F, 9'h040);

    for (int i = 0; i < 30; i++) begin
      set_cfg($urandom % 4, ($urandom % 4) == 0, $urandom % 6, $urandom % 4,
              $urandom % 2, $urandom % 4, $urandom % 2);
      run_pair(9'($urandom), 9'($urandom));
    end

    // R9 break mid-frame with a waiting character
    set_cfg(3, 0, 4, 0, 0, 0, 0);
    write_char(9'h055);
    wait_fall(t0);
    wait_until(t0 + 40);
    brk_start = 1'b1;
    @(negedge clk);
    brk_start = 1'b0;
    wait_until(t0 + 16 + 32 * 3);
    chk("R9 frame continues", tx_line, exp_bit(3, 9'h055));
    wait_until(t0 + 16 + 32 * 9);
    chk("R9 stop before break", tx_line, 1);
    wait_until(t0 + 340);
    chk("R9 break low", tx_line, 0);
    write_char(9'h0A5);
    wait_until(t0 + 700);
    chk("R9 break held", tx_line, 0);
    chk("R9 R10 char waits", hold_ready, 0);
    chk("R10 not empty in break", tx_empty, 0);
    brk_stop = 1'b1;
    @(negedge clk);
    brk_stop = 1'b0;
    chk("R9 idle after break", tx_line, 1);
    @(negedge clk);
    chk("R9 waiting char starts", tx_line, 0);
    t0 = cyc;
    frame_chk(t0, 9'h0A5);
    while (tx_empty !== 1'b1) @(negedge clk);
    chk("R1 empty after break", tx_line, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule